// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, once per clock, whether a small 32-bit in-order core with branch delay slots must enter a break, a hardware exception, a memory-management fault or an external interrupt. It then computes everything the entry changes: the new program counter, the return-address register write, the new status register, the exception status word, the fault address and the saved branch target. The core supplies its current PC, the pending branch target, three instruction-state flags (in a delay slot, after an immediate prefix, branch carried an immediate prefix), its status register, a vector base and the four kinds of request.

All results are registered and appear one cycle after the request. When `ent_vld_o` is high, the core loads `ent_pc_o`, writes `rf_data_o` into register `rf_idx_o`, takes `msr_o` as its status register, and clears its instruction-state flags and its load reservation. The exception status, fault address and branch target registers are held inside the block and are visible on `esr_o`, `ear_o` and `btr_o`.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Requests are served one per cycle in the priority break, then hardware exception, then memory fault, then interrupt; results appear one cycle after the request with `ent_vld_o` high and `ent_kind_o` coded 0 none, 1 interrupt, 2 break, 3 hardware exception, 4 memory fault.
- R2: An interrupt is taken only when status bit 1 (interrupt enable) is set, status bits 9 (exception in progress) and 3 (break in progress) are clear, and neither `in_dslot_i` nor `after_imm_i` is set.
- R3: An interrupt entry clears status bit 1, writes the current PC to register 14 and jumps to vector base + 0x10.
- R4: A break entry sets status bit 3, writes the current PC to register 16 and jumps to vector base + 0x18.
- R5: A hardware exception sets status bit 9, writes PC + 4 to register 17 and jumps to vector base + 0x20; it is ignored (lower requests are then served) when `cfg_exc_en_i` is low.
- R6: A memory fault sets status bit 9, jumps to vector base + 0x20 and writes register 17 with PC − 8 in a delay slot after an immediate-prefixed branch, PC − 4 in a plain delay slot or after an immediate prefix, and PC otherwise.
- R7: On a hardware exception or memory fault, exception status bit 12 equals `in_dslot_i`; in a delay slot the branch target register takes `btgt_i`, otherwise it keeps its value.
- R8: A memory fault writes exception status cause 16 (data protection), 17 (fetch protection), 18 (data miss) or 19 (fetch miss), sets bit 10 when `mmu_store_i` is high, and loads `fault_addr_i` into the fault address register.
- R9: An unaligned hardware exception writes cause 1, places `syn_i` in exception status bits 11:5 only when `syn_vld_i` is high, and loads `fault_addr_i` into the fault address register; another hardware exception writes `hwx_cause_i` in bits 4:0 and leaves the fault address alone.
- R10: Every entry copies status bit 11 (user mode) into bit 12 and bit 13 (virtual mode) into bit 14, then clears bits 11 and 13; other status bits pass through except those named above.
- R11: Without an entry, `msr_o`, `esr_o`, `ear_o` and `btr_o` keep their values; interrupt and break entries leave exception status, fault address and branch target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_exc_en_i | input | 1 | Hardware exceptions supported |
| vec_base_i | input | 32 | Vector base address |
| pc_i | input | 32 | Current PC |
| btgt_i | input | 32 | Pending branch target |
| in_dslot_i | input | 1 | Instruction is in a delay slot |
| after_imm_i | input | 1 | Instruction follows an immediate prefix |
| br_imm_i | input | 1 | The branch owning the delay slot had an immediate prefix |
| msr_i | input | 32 | Current status register |
| brk_req_i | input | 1 | Hardware break request |
| irq_req_i | input | 1 | External interrupt request |
| hwx_req_i | input | 1 | Hardware exception request |
| hwx_unal_i | input | 1 | Hardware exception is an unaligned data access |
| hwx_cause_i | input | 5 | Cause code of a non-unaligned hardware exception |
| syn_i | input | 7 | Saved instruction syndrome |
| syn_vld_i | input | 1 | Syndrome is valid |
| mmu_req_i | input | 1 | Memory fault request |
| mmu_miss_i | input | 1 | Fault is a miss (low: protection) |
| mmu_fetch_i | input | 1 | Fault on instruction fetch |
| mmu_store_i | input | 1 | Fault on a data store |
| fault_addr_i | input | 32 | Faulting address |
| ent_vld_o | output | 1 | Entry taken this cycle |
| ent_kind_o | output | 3 | Kind of entry |
| ent_pc_o | output | 32 | New PC |
| rf_idx_o | output | 5 | Return register index |
| rf_data_o | output | 32 | Return address |
| msr_o | output | 32 | New status register |
| esr_o | output | 32 | Exception status register |
| ear_o | output | 32 | Fault address register |
| btr_o | output | 32 | Branch target register |

## Verification
The bench builds the block with its default sizes: 32-bit words, 5-bit register index, 5-bit cause and 7-bit syndrome. With the vector base and PC as ports, random values reach address wrap for PC − 8 and PC + 4 and arbitrary vector offsets, while fully random status words exercise every gating combination of the interrupt and the pass-through of unrelated status bits. Directed cases cover each fault code with and without store, the unaligned case with and without a valid syndrome, and the disabled exception falling through to lower requests.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_IRQ  = 3'd1,
    EV_BRK  = 3'd2,
    EV_HWX  = 3'd3,
    EV_MMU  = 3'd4
  } ev_kind_e;

  // status register bit positions (save shift depends on UM/UMS and VM/VMS adjacency)
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = 12;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = 14;

  // exception status word
  localparam int XS_STORE = 10;
  localparam int XS_DS    = 12;
  localparam int XS_SYN_LSB = 5;

  localparam int CC_UNAL  = 1;
  localparam int CC_MMU_BASE = 16;

  localparam int OFF_IRQ = 'h10;
  localparam int OFF_BRK = 'h18;
  localparam int OFF_EXC = 'h20;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic     brk_req,
  input  logic     hwx_req,
  input  logic     hwx_ena,
  input  logic     mmu_req,
  input  logic     irq_req,
  input  logic     st_ie,
  input  logic     st_eip,
  input  logic     st_bip,
  input  logic     in_dslot,
  input  logic     after_imm,
  output ev_kind_e kind
);
  logic irq_ok;

  always_comb begin
    irq_ok = irq_req & st_ie & ~st_eip & ~st_bip & ~in_dslot & ~after_imm;
    if (brk_req)                kind = EV_BRK;
    else if (hwx_req & hwx_ena) kind = EV_HWX;
    else if (mmu_req)           kind = EV_MMU;
    else if (irq_ok)            kind = EV_IRQ;
    else                        kind = EV_NONE;
  end
endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RIDX_W  = 5,
  parameter int IRQ_REG = 14,
  parameter int BRK_REG = 16,
  parameter int EXC_REG = 17
) (
  input  ev_kind_e          kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              in_dslot,
  input  logic              after_imm,
  input  logic              br_imm,
  output logic [XLEN-1:0]   new_pc,
  output logic [RIDX_W-1:0] ridx,
  output logic [XLEN-1:0]   rdata
);
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

  logic [XLEN-1:0] mmu_ret;

  always_comb begin
    if (in_dslot)       mmu_ret = pc - (br_imm ? STEP2 : STEP);
    else if (after_imm) mmu_ret = pc - STEP;
    else                mmu_ret = pc;
  end

  always_comb begin
    new_pc = vec_base + XLEN'(OFF_EXC);
    ridx   = RIDX_W'(EXC_REG);
    rdata  = pc;
    unique case (kind)
      EV_IRQ: begin
        new_pc = vec_base + XLEN'(OFF_IRQ);
        ridx   = RIDX_W'(IRQ_REG);
        rdata  = pc;
      end
      EV_BRK: begin
        new_pc = vec_base + XLEN'(OFF_BRK);
        ridx   = RIDX_W'(BRK_REG);
        rdata  = pc;
      end
      EV_HWX: rdata = pc + STEP;
      EV_MMU: rdata = mmu_ret;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter int SYN_W   = 7
) (
  input  ev_kind_e           kind,
  input  logic [CAUSE_W-1:0] hwx_cause,
  input  logic               hwx_unal,
  input  logic [SYN_W-1:0]   syn,
  input  logic               syn_vld,
  input  logic               mmu_miss,
  input  logic               mmu_fetch,
  input  logic               mmu_store,
  input  logic               in_dslot,
  output logic [XLEN-1:0]    esr_next,
  output logic               esr_we,
  output logic               ear_we,
  output logic               btr_we
);
  logic [XLEN-1:0] base;

  always_comb begin
    base = '0;
    if (kind == EV_MMU) begin
      base = XLEN'(CC_MMU_BASE + 2 * int'(mmu_miss) + int'(mmu_fetch));
      base[XS_STORE] = mmu_store;
    end else if (hwx_unal) begin
      base = XLEN'(CC_UNAL);
      if (syn_vld) base = base | (XLEN'(syn) << XS_SYN_LSB);
    end else begin
      base = XLEN'(hwx_cause);
    end
    esr_next = base;
    esr_next[XS_DS] = in_dslot;
    esr_we = (kind == EV_HWX) || (kind == EV_MMU);
    ear_we = (kind == EV_MMU) || ((kind == EV_HWX) && hwx_unal);
    btr_we = esr_we && in_dslot;
  end
endmodule

// File: rtl/exc_status_upd.sv
module exc_status_upd
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ev_kind_e        kind,
  input  logic [XLEN-1:0] st_in,
  output logic [XLEN-1:0] st_out
);
  logic [XLEN-1:0] evt;

  always_comb begin
    evt = st_in;
    unique case (kind)
      EV_IRQ:         evt[ST_IE]  = 1'b0;
      EV_BRK:         evt[ST_BIP] = 1'b1;
      EV_HWX, EV_MMU: evt[ST_EIP] = 1'b1;
      default: ;
    endcase
    st_out = evt;
    st_out[ST_UMS] = evt[ST_UM];
    st_out[ST_VMS] = evt[ST_VM];
    st_out[ST_UM]  = 1'b0;
    st_out[ST_VM]  = 1'b0;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RIDX_W  = 5,
  parameter int CAUSE_W = 5,
  parameter int SYN_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_exc_en_i,
  input  logic [XLEN-1:0]    vec_base_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    btgt_i,
  input  logic               in_dslot_i,
  input  logic               after_imm_i,
  input  logic               br_imm_i,
  input  logic [XLEN-1:0]    msr_i,
  input  logic               brk_req_i,
  input  logic               irq_req_i,
  input  logic               hwx_req_i,
  input  logic               hwx_unal_i,
  input  logic [CAUSE_W-1:0] hwx_cause_i,
  input  logic [SYN_W-1:0]   syn_i,
  input  logic               syn_vld_i,
  input  logic               mmu_req_i,
  input  logic               mmu_miss_i,
  input  logic               mmu_fetch_i,
  input  logic               mmu_store_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  output logic               ent_vld_o,
  output logic [2:0]         ent_kind_o,
  output logic [XLEN-1:0]    ent_pc_o,
  output logic [RIDX_W-1:0]  rf_idx_o,
  output logic [XLEN-1:0]    rf_data_o,
  output logic [XLEN-1:0]    msr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    ear_o,
  output logic [XLEN-1:0]    btr_o
);
  ev_kind_e          kind;
  logic [XLEN-1:0]   new_pc, rdata, st_next, esr_next;
  logic [RIDX_W-1:0] ridx;
  logic              esr_we, ear_we, btr_we, take;

  exc_arbiter u_arb (
    .brk_req  (brk_req_i),
    .hwx_req  (hwx_req_i),
    .hwx_ena  (cfg_exc_en_i),
    .mmu_req  (mmu_req_i),
    .irq_req  (irq_req_i),
    .st_ie    (msr_i[ST_IE]),
    .st_eip   (msr_i[ST_EIP]),
    .st_bip   (msr_i[ST_BIP]),
    .in_dslot (in_dslot_i),
    .after_imm(after_imm_i),
    .kind     (kind)
  );

  exc_retaddr #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ret (
    .kind     (kind),
    .pc       (pc_i),
    .vec_base (vec_base_i),
    .in_dslot (in_dslot_i),
    .after_imm(after_imm_i),
    .br_imm   (br_imm_i),
    .new_pc   (new_pc),
    .ridx     (ridx),
    .rdata    (rdata)
  );

  exc_syndrome #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .SYN_W(SYN_W)) u_syn (
    .kind     (kind),
    .hwx_cause(hwx_cause_i),
    .hwx_unal (hwx_unal_i),
    .syn      (syn_i),
    .syn_vld  (syn_vld_i),
    .mmu_miss (mmu_miss_i),
    .mmu_fetch(mmu_fetch_i),
    .mmu_store(mmu_store_i),
    .in_dslot (in_dslot_i),
    .esr_next (esr_next),
    .esr_we   (esr_we),
    .ear_we   (ear_we),
    .btr_we   (btr_we)
  );

  exc_status_upd #(.XLEN(XLEN)) u_st (
    .kind  (kind),
    .st_in (msr_i),
    .st_out(st_next)
  );

  assign take = (kind != EV_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld_o  <= 1'b0;
      ent_kind_o <= EV_NONE;
      ent_pc_o   <= '0;
      rf_idx_o   <= '0;
      rf_data_o  <= '0;
      msr_o      <= '0;
      esr_o      <= '0;
      ear_o      <= '0;
      btr_o      <= '0;
    end else begin
      ent_vld_o  <= take;
      ent_kind_o <= kind;
      if (take) begin
        ent_pc_o  <= new_pc;
        rf_idx_o  <= ridx;
        rf_data_o <= rdata;
        msr_o     <= st_next;
      end
      if (esr_we) esr_o <= esr_next;
      if (ear_we) ear_o <= fault_addr_i;
      if (btr_we) btr_o <= btgt_i;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_exc_en_i,
  input logic [XLEN-1:0]   vec_base_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              in_dslot_i,
  input logic              after_imm_i,
  input logic [XLEN-1:0]   msr_i,
  input logic              brk_req_i,
  input logic              irq_req_i,
  input logic              hwx_req_i,
  input logic              mmu_req_i,
  input logic              ent_vld_o,
  input logic [2:0]        ent_kind_o,
  input logic [XLEN-1:0]   ent_pc_o,
  input logic [RIDX_W-1:0] rf_idx_o,
  input logic [XLEN-1:0]   rf_data_o,
  input logic [XLEN-1:0]   msr_o,
  input logic [XLEN-1:0]   esr_o,
  input logic [XLEN-1:0]   ear_o,
  input logic [XLEN-1:0]   btr_o
);
  assert_brk_first_R1: assert property (@(posedge clk) disable iff (rst)
    brk_req_i |=> (ent_vld_o && ent_kind_o == EV_BRK));

  assert_irq_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (ent_vld_o && ent_kind_o == EV_IRQ) |->
      ($past(msr_i[ST_IE]) && !$past(msr_i[ST_EIP]) && !$past(msr_i[ST_BIP])
       && !$past(in_dslot_i) && !$past(after_imm_i)));

  assert_irq_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (ent_vld_o && ent_kind_o == EV_IRQ) |->
      (ent_pc_o == $past(vec_base_i) + XLEN'(OFF_IRQ) && rf_idx_o == RIDX_W'(14)
       && rf_data_o == $past(pc_i) && !msr_o[ST_IE]));

  assert_hwx_off_R5: assert property (@(posedge clk) disable iff (rst)
    (hwx_req_i && !cfg_exc_en_i && !brk_req_i && !mmu_req_i && !irq_req_i) |=> !ent_vld_o);

  assert_mode_save_R10: assert property (@(posedge clk) disable iff (rst)
    ent_vld_o |-> (msr_o[ST_UMS] == $past(msr_i[ST_UM]) && msr_o[ST_VMS] == $past(msr_i[ST_VM])
                   && !msr_o[ST_UM] && !msr_o[ST_VM]));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ent_vld_o |-> ($stable(esr_o) && $stable(ear_o) && $stable(btr_o) && $stable(msr_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_exc_en_i(cfg_exc_en_i), .vec_base_i(vec_base_i),
  .pc_i(pc_i), .in_dslot_i(in_dslot_i), .after_imm_i(after_imm_i), .msr_i(msr_i),
  .brk_req_i(brk_req_i), .irq_req_i(irq_req_i), .hwx_req_i(hwx_req_i), .mmu_req_i(mmu_req_i),
  .ent_vld_o(ent_vld_o), .ent_kind_o(ent_kind_o), .ent_pc_o(ent_pc_o), .rf_idx_o(rf_idx_o),
  .rf_data_o(rf_data_o), .msr_o(msr_o), .esr_o(esr_o), .ear_o(ear_o), .btr_o(btr_o)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_exc_en_i;
  logic [31:0] vec_base_i, pc_i, btgt_i, msr_i, fault_addr_i;
  logic        in_dslot_i, after_imm_i, br_imm_i;
  logic        brk_req_i, irq_req_i, hwx_req_i, hwx_unal_i, syn_vld_i;
  logic [4:0]  hwx_cause_i;
  logic [6:0]  syn_i;
  logic        mmu_req_i, mmu_miss_i, mmu_fetch_i, mmu_store_i;
  logic        ent_vld_o;
  logic [2:0]  ent_kind_o;
  logic [31:0] ent_pc_o, rf_data_o, msr_o, esr_o, ear_o, btr_o;
  logic [4:0]  rf_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] m_esr, m_ear, m_btr;

  always #2 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    brk_req_i = 0; irq_req_i = 0; hwx_req_i = 0; mmu_req_i = 0;
    hwx_unal_i = 0; syn_vld_i = 0; hwx_cause_i = 0; syn_i = 0;
    mmu_miss_i = 0; mmu_fetch_i = 0; mmu_store_i = 0;
    in_dslot_i = 0; after_imm_i = 0; br_imm_i = 0;
  endtask

  // inputs are set at the falling edge; results checked just after the next rising edge
  task automatic step();
    int k;
    logic [31:0] xpc, xdat, xmsr, xesr;
    logic [4:0]  xidx;
    bit irq_ok;
    irq_ok = irq_req_i && msr_i[1] && !msr_i[9] && !msr_i[3] && !in_dslot_i && !after_imm_i;
    if (brk_req_i) k = 2;
    else if (hwx_req_i && cfg_exc_en_i) k = 3;
    else if (mmu_req_i) k = 4;
    else if (irq_ok) k = 1;
    else k = 0;
    xmsr = msr_i; xpc = 0; xdat = pc_i; xidx = 17;
    case (k)
      1: begin xmsr[1] = 0; xpc = vec_base_i + 32'h10; xidx = 14; end
      2: begin xmsr[3] = 1; xpc = vec_base_i + 32'h18; xidx = 16; end
      3: begin xmsr[9] = 1; xpc = vec_base_i + 32'h20; xdat = pc_i + 32'd4; end
      4: begin
        xmsr[9] = 1; xpc = vec_base_i + 32'h20;
        if (in_dslot_i) xdat = br_imm_i ? pc_i - 32'd8 : pc_i - 32'd4;
        else if (after_imm_i) xdat = pc_i - 32'd4;
      end
      default: ;
    endcase
    xmsr[12] = msr_i[11]; xmsr[14] = msr_i[13]; xmsr[11] = 0; xmsr[13] = 0;
    if (k == 3) begin
      if (hwx_unal_i) begin
        xesr = 32'd1;
        if (syn_vld_i) xesr = xesr | {20'd0, syn_i, 5'd0};
        m_ear = fault_addr_i;
      end else xesr = {27'd0, hwx_cause_i};
    end else begin
      xesr = {27'd0, 1'b1, 2'b00, mmu_miss_i, mmu_fetch_i};
      xesr[10] = mmu_store_i;
    end
    xesr[12] = in_dslot_i;
    if (k == 4) m_ear = fault_addr_i;
    if (k >= 3) begin
      m_esr = xesr;
      if (in_dslot_i) m_btr = btgt_i;
    end
    @(posedge clk); #1;
    chk("R1 valid", {31'd0, ent_vld_o}, {31'd0, k != 0});
    chk("R1 kind/R2 gate", {29'd0, ent_kind_o}, k[31:0]);
    if (k != 0) begin
      chk(k == 1 ? "R3 pc" : k == 2 ? "R4 pc" : k == 3 ? "R5 pc" : "R6 pc", ent_pc_o, xpc);
      chk("R3/R4/R5 index", {27'd0, rf_idx_o}, {27'd0, xidx});
      chk(k == 4 ? "R6 return" : "R5 return", rf_data_o, xdat);
      chk("R10 status", msr_o, xmsr);
    end
    chk(k == 4 ? "R8 esr" : k == 3 ? "R9 esr" : "R11 esr", esr_o, m_esr);
    chk("R7 btr", btr_o, m_btr);
    chk(k == 4 ? "R8 ear" : "R9/R11 ear", ear_o, m_ear);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst = 1; cfg_exc_en_i = 1; vec_base_i = 32'h0000_1000; pc_i = 32'h100;
    btgt_i = 32'h200; msr_i = 0; fault_addr_i = 0;
    m_esr = 0; m_ear = 0; m_btr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", {31'd0, ent_vld_o}, 32'd0);
    chk("R11 reset esr", esr_o, 32'd0);
    chk("R10 reset status", msr_o, 32'd0);
    @(negedge clk); rst = 0;

    // R2: interrupt blocked by each gate, then accepted
    msr_i = 32'h0000_2802; irq_req_i = 1;
    in_dslot_i = 1; step(); in_dslot_i = 0;
    after_imm_i = 1; step(); after_imm_i = 0;
    msr_i[9] = 1; step(); msr_i[9] = 0;
    msr_i[3] = 1; step(); msr_i[3] = 0;
    msr_i[1] = 0; step(); msr_i[1] = 1;
    step();
    // R1: all requests together, break wins
    brk_req_i = 1; hwx_req_i = 1; mmu_req_i = 1; step(); idle();
    // R5: exception disabled falls through to memory fault
    cfg_exc_en_i = 0; hwx_req_i = 1; mmu_req_i = 1; fault_addr_i = 32'hDEAD_0000; step();
    mmu_req_i = 0; step(); idle(); cfg_exc_en_i = 1;
    // R8 / R6 / R7: each fault code, store bit, delay-slot forms
    for (int c = 0; c < 8; c++) begin
      mmu_req_i = 1; mmu_miss_i = c[0]; mmu_fetch_i = c[1]; mmu_store_i = c[2] & ~c[1];
      in_dslot_i = (c % 3 == 1); br_imm_i = (c % 3 == 1) && c[2];
      after_imm_i = (c % 3 == 2); pc_i = 32'h4 * c; fault_addr_i = 32'hF000 + c;
      btgt_i = 32'hB000 + c; step();
    end
    idle();
    // R9: unaligned with and without syndrome, plain cause in delay slot
    hwx_req_i = 1; hwx_unal_i = 1; syn_i = 7'h5A; fault_addr_i = 32'h1233;
    syn_vld_i = 1; step(); syn_vld_i = 0; step();
    hwx_unal_i = 0; hwx_cause_i = 5'd7; in_dslot_i = 1; pc_i = 32'hFFFF_FFFC; step();
    idle();

    for (int i = 0; i < 3000; i++) begin
      int d;
      idle();
      d = $urandom % 4;
      brk_req_i = ($urandom % 8) == 0;
      hwx_req_i = ($urandom % 5) == 0;
      mmu_req_i = ($urandom % 4) == 0;
      irq_req_i = ($urandom % 2) == 0;
      cfg_exc_en_i = ($urandom % 4) != 0;
      in_dslot_i = (d == 0);
      after_imm_i = (d == 1);
      br_imm_i = (d == 0) && ($urandom % 2);
      hwx_unal_i = $urandom % 2; syn_vld_i = $urandom % 2;
      hwx_cause_i = 5'($urandom); syn_i = 7'($urandom);
      mmu_miss_i = $urandom % 2; mmu_fetch_i = $urandom % 2;
      mmu_store_i = !mmu_fetch_i && ($urandom % 2);
      msr_i = $urandom; pc_i = $urandom & 32'hFFFF_FFFC;
      btgt_i = $urandom; vec_base_i = $urandom & 32'hFFFF_FF00;
      fault_addr_i = $urandom;
      if (i % 3 == 0) begin msr_i[1] = 1; msr_i[3] = 0; msr_i[9] = 0; end
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule